// File: doc/BRIEF.md
# Int8 Segmented Matrix Multiply-Accumulate Unit

This block is a streaming datapath that treats each of its three VL-bit operands as a row of independent 128-bit segments. In every segment the first operand carries a 2×8 matrix of unsigned bytes. The second operand carries an 8×2 matrix of signed bytes, stored column by column. The third operand carries a 2×2 matrix of 32-bit accumulators. The unit returns, per segment, each accumulator plus the matching 8-way dot product. The sum wraps modulo 2^32. No element is masked, so every result element is produced on every operation.

Operands enter through a valid/ready handshake and results leave through a second one. The pipeline has two register stages. The first holds the four dot products and a copy of the accumulators. The second holds the final sums. The whole pipeline moves only when the consumer's ready is high. The producer's ready therefore mirrors the consumer's ready. When ready is low, everything freezes: items in flight are neither lost nor duplicated, and the presented result stays unchanged until it is taken. An item is accepted on an edge where valid and ready are both high. It appears on the output after the pipeline has advanced on two edges.

Top module: `mmla_int8_unit`

## Requirements
- R1: Bytes of the first operand are unsigned: within a segment, byte index i*8+k (byte 0 in the least significant bits) is A[i][k] in the range 0..255.
- R2: Bytes of the second operand are two's-complement signed: within a segment, byte index j*8+k is B[k][j] in the range -128..127.
- R3: Result (i,j) of a segment equals accumulator (i,j) plus the sum over k=0..7 of A[i][k]*B[k][j].
- R4: Within a segment, 32-bit element index i*2+j (element 0 in the least significant bits) holds accumulator (i,j) on input and result (i,j) on output.
- R5: The accumulation wraps modulo 2^32, with no saturation.
- R6: The 128-bit segments are computed independently, and VL (a nonzero multiple of 128) sets how many there are. The low 128 bits of a wide unit give the same result as a 128-bit unit fed the low 128 bits.
- R7: Every element of every segment is rewritten by each operation, regardless of earlier results.
- R8: Results leave in acceptance order. An item accepted on an edge is presented as valid after the next advancing edge, so with ready held high the latency is two cycles.
- R9: in_ready equals out_ready. While out_valid is high and out_ready is low, out_valid and out_res hold their values.
- R10: After reset, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand set is present |
| in_ready | output | 1 | Unit accepts an operand set this cycle |
| in_a | input | VL | Unsigned byte matrices, one per segment |
| in_b | input | VL | Signed byte matrices, column-major, one per segment |
| in_acc | input | VL | 32-bit accumulator tiles, one per segment |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result; also advances the pipeline |
| out_res | output | VL | Accumulated 32-bit result tiles |

## Verification
The bench builds two copies side by side from the same stimulus: one with VL=512 (four segments) and one with VL=128 (one segment) that sees the low 128 bits. Every result from the wide copy is compared against an independent model, and its low segment is compared against the narrow copy. This brings segment independence and the count of segments derived from VL within reach. It also exercises saturating byte values in all eight lanes, accumulators at the 32-bit wrap, and random back-pressure that stalls items in both stages.

// File: rtl/mmla_pkg.sv
package mmla_pkg;
  localparam int SEG_W   = 128;
  localparam int BYTE_W  = 8;
  localparam int DOT_LEN = 8;
  localparam int TILE_R  = 2;
  localparam int TILE_C  = 2;
  localparam int ACC_W   = 32;
  localparam int TILE_N  = TILE_R * TILE_C;
  localparam int ROW_W   = DOT_LEN * BYTE_W;
  // 8 products of 9-bit by 8-bit signed values fit in 20 bits
  localparam int DOT_W   = 20;
  localparam int DOT_MIN = -(DOT_LEN * 255 * 128);
  localparam int DOT_MAX = DOT_LEN * 255 * 127;

  typedef logic signed [DOT_W-1:0] dot_t;
  typedef logic [ACC_W-1:0]        acc_t;
endpackage

// File: rtl/mmla_dot8.sv
module mmla_dot8
  import mmla_pkg::*;
(
  input  logic [ROW_W-1:0] row_u,
  input  logic [ROW_W-1:0] col_s,
  output dot_t             dot
);
  logic any_neg;

  always_comb begin
    dot     = '0;
    any_neg = 1'b0;
    for (int k = 0; k < DOT_LEN; k++) begin
      dot = dot + (dot_t'(signed'({1'b0, row_u[k*BYTE_W +: BYTE_W]})) *
                   dot_t'(signed'(col_s[k*BYTE_W +: BYTE_W])));
      any_neg = any_neg | col_s[k*BYTE_W + BYTE_W - 1];
    end
  end

  // Unsigned row bytes times non-negative column bytes can never go negative
  always_comb begin
    if (!any_neg) begin
      assert_nonneg_R1: assert (dot >= 0)
        else $error("dot product negative with non-negative column");
    end
    assert_range_R2: assert ((int'(dot) >= DOT_MIN) && (int'(dot) <= DOT_MAX))
      else $error("dot product outside signed byte range");
  end
endmodule

// File: rtl/mmla_segment.sv
module mmla_segment
  import mmla_pkg::*;
(
  input  logic             clk,
  input  logic             en,
  input  logic [SEG_W-1:0] a_seg,
  input  logic [SEG_W-1:0] b_seg,
  input  logic [SEG_W-1:0] c_seg,
  output logic [SEG_W-1:0] r_seg
);
  dot_t dot_w [TILE_N];
  dot_t dot_q [TILE_N];
  acc_t acc_q [TILE_N];

  for (genvar gi = 0; gi < TILE_R; gi++) begin : g_row
    for (genvar gj = 0; gj < TILE_C; gj++) begin : g_col
      mmla_dot8 u_dot (
        .row_u (a_seg[gi*ROW_W +: ROW_W]),
        .col_s (b_seg[gj*ROW_W +: ROW_W]),
        .dot   (dot_w[gi*TILE_C + gj])
      );
    end
  end

  // stage 1: dot products and accumulators; stage 2: wrapped sums
  always_ff @(posedge clk) begin
    if (en) begin
      for (int e = 0; e < TILE_N; e++) begin
        dot_q[e]                 <= dot_w[e];
        acc_q[e]                 <= c_seg[e*ACC_W +: ACC_W];
        r_seg[e*ACC_W +: ACC_W]  <= acc_q[e] + ACC_W'(dot_q[e]);
      end
    end
  end
endmodule

// File: rtl/mmla_int8_unit.sv
module mmla_int8_unit
  import mmla_pkg::*;
#(
  parameter int VL = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [VL-1:0] in_a,
  input  logic [VL-1:0] in_b,
  input  logic [VL-1:0] in_acc,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [VL-1:0] out_res
);
  localparam int SEGS = VL / SEG_W;

  if ((VL % SEG_W) != 0 || VL == 0) begin : g_bad_vl
    $error("VL must be a nonzero multiple of 128");
  end

  logic advance;
  logic v1;

  assign advance  = out_ready;
  assign in_ready = advance;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1        <= 1'b0;
      out_valid <= 1'b0;
    end else if (advance) begin
      v1        <= in_valid;
      out_valid <= v1;
    end
  end

  for (genvar gs = 0; gs < SEGS; gs++) begin : g_seg
    mmla_segment u_seg (
      .clk   (clk),
      .en    (advance),
      .a_seg (in_a  [gs*SEG_W +: SEG_W]),
      .b_seg (in_b  [gs*SEG_W +: SEG_W]),
      .c_seg (in_acc[gs*SEG_W +: SEG_W]),
      .r_seg (out_res[gs*SEG_W +: SEG_W])
    );
  end

  assert_hold_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);

  assert_hold_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_res));

  assert_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(v1));

  assert_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !v1 |=> !out_valid);
endmodule

// File: tb/tb_mmla_int8_unit.sv
module tb_mmla_int8_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 512;
  localparam int NW = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic [W-1:0] in_a = '0, in_b = '0, in_acc = '0;
  logic in_ready, out_valid, n_in_ready, n_out_valid;
  logic [W-1:0]  out_res;
  logic [NW-1:0] n_out_res;

  int checks = 0;
  int errors = 0;
  int ready_mode = 0;  // 0 high, 1 random, 2 low
  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mmla_int8_unit #(.VL(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_acc(in_acc),
    .out_valid(out_valid), .out_ready(out_ready), .out_res(out_res));

  mmla_int8_unit #(.VL(NW)) dut_narrow (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(n_in_ready),
    .in_a(in_a[NW-1:0]), .in_b(in_b[NW-1:0]), .in_acc(in_acc[NW-1:0]),
    .out_valid(n_out_valid), .out_ready(out_ready), .out_res(n_out_res));

  function automatic logic [W-1:0] model(input logic [W-1:0] a, b, c);
    logic [W-1:0] r;
    for (int s = 0; s < W/128; s++)
      for (int i = 0; i < 2; i++)
        for (int j = 0; j < 2; j++) begin
          int sum;
          sum = int'(c[s*128 + (i*2+j)*32 +: 32]);
          for (int k = 0; k < 8; k++)
            sum += int'(a[s*128 + (i*8+k)*8 +: 8]) *
                   int'($signed(b[s*128 + (j*8+k)*8 +: 8]));
          r[s*128 + (i*2+j)*32 +: 32] = sum;
        end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic send(input logic [W-1:0] a, b, c, input string tag);
    @(negedge clk);
    in_a = a; in_b = b; in_acc = c; in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back(model(a, b, c));
    tag_q.push_back(tag);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  function automatic logic [W-1:0] rnd();
    logic [W-1:0] v;
    for (int w = 0; w < W/32; w++) v[w*32 +: 32] = $urandom;
    return v;
  endfunction

  // ready driver
  always @(negedge clk) begin
    if (ready_mode == 1)      out_ready <= (($urandom % 3) != 0);
    else if (ready_mode == 2) out_ready <= 1'b0;
    else                      out_ready <= 1'b1;
  end

  // scoreboard monitor
  initial begin
    logic prev_stall = 1'b0;
    logic [W-1:0] prev_res = '0;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        if (prev_stall) begin
          check(out_valid == 1'b1, "R9", "valid dropped under stall", W'(out_valid), W'(1));
          check(out_res == prev_res, "R9", "data moved under stall", out_res, prev_res);
        end
        check(n_out_valid == out_valid, "R6", "narrow valid", W'(n_out_valid), W'(out_valid));
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R8", "unexpected result", out_res, '0);
          end else begin
            logic [W-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(out_res == e, t, "wide result", out_res, e);
            check(n_out_res == e[NW-1:0], {t, " R6"}, "narrow result",
                  W'(n_out_res), W'(e[NW-1:0]));
          end
        end
        prev_stall = out_valid && !out_ready;
        prev_res   = out_res;
      end
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [W-1:0] a, b, c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    check(out_valid == 1'b0, "R10", "valid after reset", W'(out_valid), '0);
    check(in_ready == out_ready, "R9", "in_ready mirrors out_ready", W'(in_ready), W'(out_ready));
    ready_mode = 2;
    @(negedge clk); #2;
    check(in_ready == 1'b0, "R9", "in_ready low with consumer stalled", W'(in_ready), '0);
    ready_mode = 0;
    @(negedge clk);

    // latency: R8
    send({(W/8){8'd2}}, {(W/8){8'd3}}, '0, "R8 R3");
    @(negedge clk); #2;
    check(out_valid == 1'b0, "R8", "not valid after one edge", W'(out_valid), '0);
    @(negedge clk); #2;
    check(out_valid == 1'b1, "R8", "valid after two edges", W'(out_valid), W'(1));

    // extremes: 255 * -128 in all lanes, R1 R2
    send({(W/8){8'hFF}}, {(W/8){8'h80}}, '0, "R1 R2");
    check(model({(W/8){8'hFF}}, {(W/8){8'h80}}, '0) == {(W/32){32'hFFFC0400}},
          "R1 R2", "model extreme constant", '0, '0);
    send({(W/8){8'hFF}}, {(W/8){8'h7F}}, {(W/32){32'hFFFFFFF0}}, "R5");
    send({(W/8){8'hFF}}, {(W/8){8'h7F}}, {(W/32){32'h7FFFFFFF}}, "R5");
    send({(W/8){8'hFF}}, {(W/8){8'h80}}, {(W/32){32'h00000010}}, "R5");

    // layout: distinct bytes and accumulators, R4 R7
    for (int n = 0; n < W/8; n++) begin
      a[n*8 +: 8] = 8'(n * 7 + 1);
      b[n*8 +: 8] = 8'(n * 13 - 60);
    end
    for (int n = 0; n < W/32; n++) c[n*32 +: 32] = 32'h1000_0000 * 32'(n % 16) + 32'(n);
    send(a, b, c, "R4 R7 R3");
    send(a, b, '0, "R7");

    // random traffic with back-pressure
    ready_mode = 1;
    for (int t = 0; t < 300; t++) send(rnd(), rnd(), rnd(), "R3 R6 R9");
    ready_mode = 0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule